// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds subroutine and interrupt return addresses for a small Harvard-architecture CPU. It keeps them in a private register array that is part of neither program memory nor data memory. The program counter logic raises `push_en` with the current program counter on `push_addr` when a call executes or an interrupt branch is taken. It raises `pop_en` when any return-type instruction executes. The address on the top of the stack is always present on `top_addr`.

The stack pointer is internal and has no software path. It advances on a push and steps back on a pop, modulo `DEPTH`. An extra push past the last level overwrites the oldest entry. An extra pop past the first level presents whatever stale entry the pointer reaches. Neither case raises a flag.

Each cycle is decoded into one of three operations:
- `OP_HOLD`: no request, or the cycle is otherwise idle.
- `OP_PUSH`: `push_en` is high. This holds whether or not `pop_en` is also high.
- `OP_POP`: `pop_en` is high and `push_en` is low.

The pointer moves as follows:
- `OP_PUSH` writes the slot at the pointer, then advances the pointer.
- `OP_POP` steps the pointer back.
- `OP_HOLD` keeps the pointer where it is.

Top module: `ras_stack`

## Requirements
- R1: An active-low reset on `rst_n` clears the pointer to zero and every entry to zero. Right after reset, `top_addr` reads 0.
- R2: When `push_en` is high at a rising clock edge, `top_addr` equals the pushed `push_addr` from that edge on.
- R3: A pop with no push presents the entry written before the current top, so return addresses come back in reverse order of their pushes.
- R4: The stack has `DEPTH` levels (default 8). Push number `DEPTH+1` overwrites the slot of the first push. After `DEPTH` pops, `top_addr` shows the last pushed value again, not the overwritten one.
- R5: Pops in excess of pushes wrap the pointer from 0 to `DEPTH-1` and present the stale content of the slot reached. Directly after reset this content is 0. No error indication exists.
- R6: When `push_en` and `pop_en` are both high in one cycle, only the push takes effect and the pop request is discarded.
- R7: When neither request is high, `top_addr` and the stack contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Save `push_addr` as the new top of stack |
| push_addr | input | AW (13) | Return address to save |
| pop_en | input | 1 | Discard the top of stack |
| top_addr | output | AW (13) | Current top-of-stack address |

## Verification
The stack is first driven with a short call/return nest. This checks LIFO ordering and that a push is visible on the very next cycle. A run of `DEPTH+1` pushes followed by `DEPTH` pops separates a circular buffer from a saturating one: the oldest value must be gone, and the newest must reappear. Extra pops, both right after reset and after the buffer has been filled, show that the pointer wraps and that stale content is returned rather than zero or a held value. Cycles with both requests high, and idle cycles placed between operations, distinguish push priority from pop priority and from drifting state.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } ras_op_e;
endpackage

// File: rtl/ras_arbiter.sv
module ras_arbiter
    import ras_pkg::*;
(
    input  logic    push_en,
    input  logic    pop_en,
    output ras_op_e op
);
    // Push outranks pop when both arrive together (R6).
    always_comb begin
        unique case ({push_en, pop_en})
            2'b10,
            2'b11:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/ras_pointer.sv
module ras_pointer
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ras_op_e       op,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx
);
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;

    function automatic logic [PW-1:0] step_fwd(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] step_back(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        unique case (op)
            OP_PUSH: ptr_d = step_fwd(ptr_q);
            OP_POP:  ptr_d = step_back(ptr_q);
            default: ptr_d = ptr_q;
        endcase
    end

    assign wr_idx = ptr_q;
    assign rd_idx = step_back(ptr_q);

    // R5: a lone pop moves the pointer back one level, wrapping at zero
    p_pop_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |=> (wr_idx == ((($past(wr_idx)) == '0) ? PW'(DEPTH - 1) : $past(wr_idx) - PW'(1))));

    // R7: the pointer rests while no request arrives
    p_hold_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(wr_idx));
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
    parameter int DEPTH = 8,
    parameter int AW    = 13,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);
    logic [AW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q[i] <= '0;
            else if (we && (wr_idx == PW'(i)))   slot_q[i] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

    // R2: the addressed slot holds the written value after the edge
    p_slot_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (slot_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 13,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    output logic [AW-1:0] top_addr
);
    ras_op_e       op;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;

    ras_arbiter u_arb (
        .push_en (push_en),
        .pop_en  (pop_en),
        .op      (op)
    );

    ras_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    ras_storage #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (op == OP_PUSH),
        .wr_idx  (wr_idx),
        .wr_data (push_addr),
        .rd_idx  (rd_idx),
        .rd_data (top_addr)
    );

    // R2: a pushed address is on top one cycle later
    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |=> (top_addr == $past(push_addr)));

    // R6: simultaneous requests behave as a push
    p_push_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> (top_addr == $past(push_addr)));

    // R7: an idle cycle leaves the top address unchanged
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !pop_en) |=> $stable(top_addr));
endmodule

// File: tb/ras_stack_bench.sv
module ras_stack_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_en = 1'b0;
    logic          pop_en = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic [AW-1:0] top_addr;

    always #4 clk = ~clk;   // 125 MHz

    ras_stack #(.DEPTH(DEPTH), .AW(AW)) u_ras_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_addr (push_addr),
        .pop_en    (pop_en),
        .top_addr  (top_addr)
    );

    int checks = 0;
    int errors = 0;

    // Reference model built from the requirements
    logic [AW-1:0] m_slot [DEPTH];
    int            m_ptr = 0;

    logic [AW-1:0] exp_q [$];
    string         tag_q [$];

    function automatic logic [AW-1:0] model_top();
        return m_slot[(m_ptr + DEPTH - 1) % DEPTH];
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s top_addr actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of requests and queues the expected top
    task automatic drive(input logic psh, input logic pp, input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        push_en   = psh;
        pop_en    = pp;
        push_addr = a;
        if (psh) begin
            m_slot[m_ptr] = a;
            m_ptr = (m_ptr + 1) % DEPTH;
        end else if (pp) begin
            m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
        end
        exp_q.push_back(model_top());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each rising edge once results are due
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                automatic logic [AW-1:0] e = exp_q.pop_front();
                automatic string         t = tag_q.pop_front();
                check(t, top_addr, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
        repeat (3) @(negedge clk);
        check("R1", top_addr, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", top_addr, '0);

        // R5: pop straight after reset returns stale zero
        drive(1'b0, 1'b1, '0, "R5");
        drive(1'b1, 1'b0, 13'h0111, "R2");   // refill to realign
        // R2/R3: nested calls and returns
        drive(1'b1, 1'b0, 13'h0100, "R2");
        drive(1'b1, 1'b0, 13'h00AB, "R2");
        drive(1'b1, 1'b0, 13'h1FFF, "R2");
        drive(1'b0, 1'b0, '0,       "R7");
        drive(1'b0, 1'b0, 13'h0555, "R7");
        drive(1'b0, 1'b1, '0,       "R3");
        drive(1'b0, 1'b1, '0,       "R3");
        // R6: both requests together act as a push
        drive(1'b1, 1'b1, 13'h0AAA, "R6");
        drive(1'b0, 1'b1, '0,       "R3");
        drive(1'b1, 1'b1, 13'h1234, "R6");
        drive(1'b0, 1'b0, '0,       "R7");

        // R4: DEPTH+1 pushes then DEPTH pops
        for (int i = 0; i <= DEPTH; i++)
            drive(1'b1, 1'b0, AW'(13'h0800 + i * 13'h0013), "R4");
        for (int i = 0; i < DEPTH; i++)
            drive(1'b0, 1'b1, '0, "R4");
        // R5: further pops wrap and return stale entries
        for (int i = 0; i < DEPTH + 3; i++)
            drive(1'b0, 1'b1, '0, "R5");
        drive(1'b0, 1'b0, '0, "R7");

        @(negedge clk);
        push_en = 1'b0;
        pop_en  = 1'b0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 pending results actual=%0d expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule